// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit-rate timing for a serial port that can work as an asynchronous UART or as a clock-synchronous shifter. Everything runs on one fast system clock. The bit clocks leave the block as one-cycle enable pulses: `tx_tick` marks a transmit shift and `rx_tick` marks a receive sample. The rate chain has three stages. First, a base clock is chosen as the system clock or half of it. Next, a prescale factor of 1, 8 or 32 is applied. Last, an 8-bit reload divider divides by (n+1). The current mode then applies a final divide: by 16 for the UART modes, or by 2 when the block drives the serial clock pin itself.

In the external-clock synchronous mode, the serial clock pin is an input. The pin is synchronised into the system clock, and its edges become the enable pulses. One polarity bit sits between the pin and the shift timing, whichever way the pin is driven. The receive and transmit data lines each have their own inversion option. A shared handshake pin can be disabled, used as a clear-to-send input, or used as a request-to-send output.

A small controller owns the mode. Its state is recomputed from the mode code and the clock-direction bit on every cycle:
- `ST_OFF` is entered for codes 000, 011 and 111.
- `ST_ASYNC` is entered for codes 010, 100, 101 and 110.
- `ST_SYNC_INT` is entered for code 001 with the internal clock selected.
- `ST_SYNC_EXT` is entered for code 001 with the external clock selected.

Any state can move directly to any other. The transition happens on the clock edge after the configuration changes. On that edge the final-divide counter restarts and the internal shift clock returns to its high idle level.

Top module: `sio_clkgen`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_tick` and `rx_tick` are 0, `sclk_oe` is 0, and `sclk_out` is 1 when `cfg_clk_inv` is 0.
- R2: With `cfg_half_base`=1 the base clock is one pulse every 2 system cycles; with 0 it is every cycle. This doubles or halves every bit-clock period.
- R3: `cfg_src_sel` 00 feeds the base clock to the divider, 01 feeds the base divided by 8, and 10 feeds the base divided by 32. Code 11 feeds nothing, so no ticks occur.
- R4: The reload divider emits one pulse every (n+1) source pulses, with n = `cfg_div_n` (0..255). A new n is taken only when the count reloads, so the interval already in progress keeps the old length.
- R5: In mode codes 010, 100, 101 and 110, `tx_tick` and `rx_tick` pulse together once every 16 divider pulses.
- R6: In mode 001 with `cfg_ext_clk`=0, `sclk_oe`=1 and the shift clock toggles on every divider pulse, starting from high. `tx_tick` pulses in the cycle the shift clock falls, and `rx_tick` pulses in the cycle it rises, half a period later.
- R7: In mode 001 with `cfg_ext_clk`=1, `sclk_oe`=0. A rising edge of the shift clock taken from `sclk_in` pulses `rx_tick` once, and a falling edge pulses `tx_tick` once. In either case the pulse appears on the third rising system-clock edge after the pin changes.
- R8: `cfg_clk_inv`=1 inverts the shift clock against the pin in both directions. `sclk_out` is then low where it would otherwise be high, and an external rising pin edge produces `tx_tick`.
- R9: `rxd_core` = `rxd_pin` XOR `cfg_rx_inv`, and `txd_pin` = `txd_core` XOR `cfg_tx_inv`.
- R10: With `cfg_hs_off`=1 the handshake pin is not driven and `cts_n_core` is 0. When the pin is enabled and `cfg_hs_rts`=1, it is driven with `rts_n_core`. When the pin is enabled and `cfg_hs_rts`=0, it is an input copied to `cts_n_core`.
- R11: Mode codes 000, 011 and 111 give no `tx_tick` or `rx_tick` and leave `sclk_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_base | input | 1 | 1: base clock is the system clock divided by 2 |
| cfg_src_sel | input | 2 | Prescale select (00 ÷1, 01 ÷8, 10 ÷32, 11 none) |
| cfg_div_n | input | 8 | Reload value n, divide by n+1 |
| cfg_mode | input | 3 | Serial mode code |
| cfg_ext_clk | input | 1 | 1: synchronous mode takes its clock from the pin |
| cfg_clk_inv | input | 1 | Shift-clock polarity inversion |
| cfg_rx_inv | input | 1 | Receive data inversion |
| cfg_tx_inv | input | 1 | Transmit data inversion |
| cfg_hs_off | input | 1 | 1: handshake pin unused |
| cfg_hs_rts | input | 1 | 1: handshake pin is RTS output, 0: CTS input |
| sclk_in | input | 1 | Serial clock pin input value |
| sclk_out | output | 1 | Serial clock pin output value |
| sclk_oe | output | 1 | Serial clock pin output enable |
| rxd_pin | input | 1 | Receive data from the pin |
| rxd_core | output | 1 | Receive data to the shifter |
| txd_core | input | 1 | Transmit data from the shifter |
| txd_pin | output | 1 | Transmit data to the pin |
| hs_pin_in | input | 1 | Handshake pin input value |
| hs_pin_out | output | 1 | Handshake pin output value |
| hs_pin_oe | output | 1 | Handshake pin output enable |
| rts_n_core | input | 1 | Request-to-send from the shifter, active low |
| cts_n_core | output | 1 | Clear-to-send to the shifter, active low |
| tx_tick | output | 1 | One-cycle transmit shift enable |
| rx_tick | output | 1 | One-cycle receive sample enable |

## Verification
Any wrong count in the prescaler or the reload divider shows up as a `tx_tick` that arrives one or more cycles early or late. In the UART modes that error is multiplied by 16, so it is visible within a single bit period. A wrong state decode is visible on the first cycle after the mode change: either `sclk_oe` takes the wrong value, or the ticks appear in a mode that should be silent. A missed reload of n, or a reload taken too early, shows as an interval between shift-clock toggles that matches neither the old length nor the new one. A synchroniser with the wrong depth moves an external edge's tick off its third-cycle slot.

// File: rtl/sio_clkgen_pkg.sv
package sio_clkgen_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ASYNC,
        ST_SYNC_INT,
        ST_SYNC_EXT
    } clk_state_e;

    localparam logic [1:0] SRC_BASE  = 2'b00;
    localparam logic [1:0] SRC_FINE  = 2'b01;
    localparam logic [1:0] SRC_COARSE = 2'b10;

    // Maps a mode code and clock direction onto the controller state (R5, R6, R7, R11)
    function automatic clk_state_e decode_mode(input logic [2:0] code, input logic ext);
        clk_state_e st;
        case (code)
            3'b001:                         st = ext ? ST_SYNC_EXT : ST_SYNC_INT;
            3'b010, 3'b100, 3'b101, 3'b110: st = ST_ASYNC;
            default:                        st = ST_OFF;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/sio_prescale.sv
module sio_prescale
    import sio_clkgen_pkg::*;
#(
    parameter int FINE_DIV   = 8,
    parameter int COARSE_DIV = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_base,
    input  logic [1:0] src_sel,
    output logic       src_tick
);
    localparam int CW = $clog2(COARSE_DIV);
    localparam int FW = $clog2(FINE_DIV);

    logic          phase_q;
    logic          base_en;
    logic [CW-1:0] cnt_q;
    logic          fine_tick;
    logic          coarse_tick;

    // Base clock: every cycle, or every other cycle (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign base_en = half_base ? phase_q : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (base_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fine_tick   = base_en && (cnt_q[FW-1:0] == FW'(FINE_DIV - 1));
    assign coarse_tick = base_en && (cnt_q == CW'(COARSE_DIV - 1));

    // Source select (R3)
    always_comb begin
        unique case (src_sel)
            SRC_BASE:   src_tick = base_en;
            SRC_FINE:   src_tick = fine_tick;
            SRC_COARSE: src_tick = coarse_tick;
            default:    src_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/sio_reload_div.sv
module sio_reload_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] reload_n,
    output logic             brg_tick
);
    logic [DIV_W-1:0] cnt_q;

    // Terminal count pulse; n is sampled only at reload (R4)
    assign brg_tick = src_tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (src_tick) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_n;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_final_div.sv
module sio_final_div
    import sio_clkgen_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  clk_state_e state,
    input  logic       restart,
    input  logic       brg_tick,
    input  logic       pin_clk,
    input  logic       clk_inv,
    output logic       int_level,
    output logic       tx_tick,
    output logic       rx_tick
);
    localparam int OW = $clog2(OVERSAMPLE);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [OW-1:0]          os_cnt_q;
    logic                   level_q;
    logic                   ext_prev_q;
    logic                   ext_level;
    logic                   os_wrap;

    // Pin synchroniser chain (R7)
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin_clk;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_clk};
            end
        end
    endgenerate

    assign ext_level = sync_q[SYNC_STAGES-1] ^ clk_inv;
    assign os_wrap   = brg_tick && (os_cnt_q == OW'(OVERSAMPLE - 1));
    assign int_level = level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev_q <= 1'b1;
        end else begin
            ext_prev_q <= ext_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt_q <= '0;
            level_q  <= 1'b1;
            tx_tick  <= 1'b0;
            rx_tick  <= 1'b0;
        end else if (restart) begin
            os_cnt_q <= '0;
            level_q  <= 1'b1;
            tx_tick  <= 1'b0;
            rx_tick  <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    tx_tick <= 1'b0;
                    rx_tick <= 1'b0;
                end
                ST_ASYNC: begin
                    if (brg_tick) os_cnt_q <= os_cnt_q + 1'b1;
                    tx_tick <= os_wrap;
                    rx_tick <= os_wrap;
                end
                ST_SYNC_INT: begin
                    if (brg_tick) level_q <= ~level_q;
                    tx_tick <= brg_tick && level_q;
                    rx_tick <= brg_tick && !level_q;
                end
                ST_SYNC_EXT: begin
                    tx_tick <= ext_prev_q && !ext_level;
                    rx_tick <= !ext_prev_q && ext_level;
                end
            endcase
        end
    end

endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
    import sio_clkgen_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int FINE_DIV    = 8,
    parameter int COARSE_DIV  = 32,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_half_base,
    input  logic [1:0]       cfg_src_sel,
    input  logic [DIV_W-1:0] cfg_div_n,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_ext_clk,
    input  logic             cfg_clk_inv,
    input  logic             cfg_rx_inv,
    input  logic             cfg_tx_inv,
    input  logic             cfg_hs_off,
    input  logic             cfg_hs_rts,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    input  logic             rxd_pin,
    output logic             rxd_core,
    input  logic             txd_core,
    output logic             txd_pin,
    input  logic             hs_pin_in,
    output logic             hs_pin_out,
    output logic             hs_pin_oe,
    input  logic             rts_n_core,
    output logic             cts_n_core,
    output logic             tx_tick,
    output logic             rx_tick
);
    clk_state_e state_q;
    clk_state_e state_d;
    logic       restart;
    logic       src_tick;
    logic       brg_tick;
    logic       int_level;

    // Mode controller: next state decoded from configuration
    always_comb begin
        state_d = decode_mode(cfg_mode, cfg_ext_clk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign restart = (state_d != state_q);

    // Mode-dependent pin outputs (R6, R7, R8, R11)
    always_comb begin
        unique case (state_q)
            ST_SYNC_INT: sclk_oe = 1'b1;
            ST_OFF,
            ST_ASYNC,
            ST_SYNC_EXT: sclk_oe = 1'b0;
        endcase
        sclk_out = int_level ^ cfg_clk_inv;
    end

    // Data polarity (R9)
    assign rxd_core = rxd_pin ^ cfg_rx_inv;
    assign txd_pin  = txd_core ^ cfg_tx_inv;

    // Handshake pin routing (R10)
    assign hs_pin_oe  = !cfg_hs_off && cfg_hs_rts;
    assign hs_pin_out = hs_pin_oe ? rts_n_core : 1'b1;
    assign cts_n_core = (!cfg_hs_off && !cfg_hs_rts) ? hs_pin_in : 1'b0;

    sio_prescale #(
        .FINE_DIV   (FINE_DIV),
        .COARSE_DIV (COARSE_DIV)
    ) i_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_base (cfg_half_base),
        .src_sel   (cfg_src_sel),
        .src_tick  (src_tick)
    );

    sio_reload_div #(
        .DIV_W (DIV_W)
    ) i_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .reload_n (cfg_div_n),
        .brg_tick (brg_tick)
    );

    sio_final_div #(
        .OVERSAMPLE  (OVERSAMPLE),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_final (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .restart   (restart),
        .brg_tick  (brg_tick),
        .pin_clk   (sclk_in),
        .clk_inv   (cfg_clk_inv),
        .int_level (int_level),
        .tx_tick   (tx_tick),
        .rx_tick   (rx_tick)
    );

endmodule

// File: rtl/sio_clkgen_chk.sv
module sio_clkgen_chk
    import sio_clkgen_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input clk_state_e state_q,
    input logic       cfg_clk_inv,
    input logic       sclk_out,
    input logic       sclk_oe,
    input logic       tx_tick,
    input logic       rx_tick
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_tick && !rx_tick));

    assert_async_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASYNC) |-> (tx_tick == rx_tick));

    assert_sync_fall_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && $past(sclk_oe) && !cfg_clk_inv && $stable(cfg_clk_inv) && $fell(sclk_out))
        |-> tx_tick);

    assert_sync_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe |-> !(tx_tick && rx_tick));

    assert_ext_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_EXT) |-> !sclk_oe);

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && $past(state_q == ST_OFF)) |-> (!tx_tick && !rx_tick && !sclk_oe));

endmodule

bind sio_clkgen sio_clkgen_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .cfg_clk_inv (cfg_clk_inv),
    .sclk_out    (sclk_out),
    .sclk_oe     (sclk_oe),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick)
);

// File: tb/test_sio_clkgen.sv
`timescale 1ns/1ps
module test_sio_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_half_base = 1'b0;
    logic [1:0] cfg_src_sel = 2'b00;
    logic [7:0] cfg_div_n = 8'd0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_ext_clk = 1'b0;
    logic       cfg_clk_inv = 1'b0;
    logic       cfg_rx_inv = 1'b0;
    logic       cfg_tx_inv = 1'b0;
    logic       cfg_hs_off = 1'b1;
    logic       cfg_hs_rts = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sclk_oe;
    logic       rxd_pin = 1'b0;
    logic       rxd_core;
    logic       txd_core = 1'b0;
    logic       txd_pin;
    logic       hs_pin_in = 1'b1;
    logic       hs_pin_out, hs_pin_oe;
    logic       rts_n_core = 1'b1;
    logic       cts_n_core;
    logic       tx_tick, rx_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sio_clkgen i_sio_clkgen (
        .clk(clk), .rst_n(rst_n), .cfg_half_base(cfg_half_base), .cfg_src_sel(cfg_src_sel),
        .cfg_div_n(cfg_div_n), .cfg_mode(cfg_mode), .cfg_ext_clk(cfg_ext_clk),
        .cfg_clk_inv(cfg_clk_inv), .cfg_rx_inv(cfg_rx_inv), .cfg_tx_inv(cfg_tx_inv),
        .cfg_hs_off(cfg_hs_off), .cfg_hs_rts(cfg_hs_rts), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rxd_pin(rxd_pin), .rxd_core(rxd_core),
        .txd_core(txd_core), .txd_pin(txd_pin), .hs_pin_in(hs_pin_in),
        .hs_pin_out(hs_pin_out), .hs_pin_oe(hs_pin_oe), .rts_n_core(rts_n_core),
        .cts_n_core(cts_n_core), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic configure(input bit half, input logic [1:0] src, input logic [7:0] n,
                             input logic [2:0] mode, input bit ext);
        @(negedge clk);
        cfg_half_base = half;
        cfg_src_sel   = src;
        cfg_div_n     = n;
        cfg_mode      = mode;
        cfg_ext_clk   = ext;
    endtask

    // Behavioural model: once locked on a tick, tx/rx are predicted every cycle
    task automatic measure(input string req, input int period, input bit sync_int);
        int seen = 0;
        int guard = 0;
        int bad = 0;
        int first_bad = 0;
        bit exp_tx, exp_rx;
        while (seen < 2 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (tx_tick) seen++;
        end
        if (seen < 2) begin
            check(1'b0, req, "ticks seen before timeout", seen, 2);
            return;
        end
        for (int c = 1; c <= 3 * period; c++) begin
            @(negedge clk);
            exp_tx = ((c % period) == 0);
            exp_rx = sync_int ? ((c % period) == period / 2) : exp_tx;
            if (tx_tick !== exp_tx || rx_tick !== exp_rx) begin
                if (bad == 0) first_bad = c;
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("period %0d: mismatching cycles (first at %0d)",
              period, first_bad), bad, 0);
    endtask

    task automatic expect_silence(input string req, input int cycles);
        int hits = 0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (tx_tick || rx_tick || sclk_oe) hits++;
        end
        check(hits == 0, req, "cycles with a tick or driven clock", hits, 0);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        int prev;
        int gap;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!tx_tick && !rx_tick, "R1", "ticks in reset", tx_tick + rx_tick, 0);
        check(!sclk_oe && sclk_out, "R1", "clock pin in reset (oe,out)", {sclk_oe, sclk_out}, 1);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(!tx_tick && !rx_tick && !sclk_oe, "R1", "outputs after reset",
              {tx_tick, rx_tick, sclk_oe}, 0);

        // R5 / R3 / R2 / R4 asynchronous rates: base * prescale * (n+1) * 16
        configure(0, 2'b00, 8'd0, 3'b010, 0);  measure("R5", 16, 0);
        configure(1, 2'b00, 8'd0, 3'b010, 0);  measure("R2", 32, 0);
        configure(0, 2'b01, 8'd1, 3'b010, 0);  measure("R3", 256, 0);
        configure(0, 2'b10, 8'd0, 3'b010, 0);  measure("R3", 512, 0);
        configure(1, 2'b10, 8'd3, 3'b010, 0);  measure("R2", 4096, 0);
        configure(0, 2'b00, 8'd2, 3'b100, 0);  measure("R5", 48, 0);
        configure(0, 2'b00, 8'd2, 3'b101, 0);  measure("R5", 48, 0);
        configure(0, 2'b00, 8'd2, 3'b110, 0);  measure("R5", 48, 0);

        // R6 internal synchronous: period 2*(n+1)*base*prescale
        configure(0, 2'b00, 8'd4, 3'b001, 0);  measure("R6", 10, 1);
        check(sclk_oe, "R6", "clock pin driven", sclk_oe, 1);
        configure(0, 2'b00, 8'd255, 3'b001, 0); measure("R4", 512, 1);
        configure(1, 2'b01, 8'd0, 3'b001, 0);  measure("R6", 32, 1);

        // R8 internal inversion: at a tx tick the clock just fell
        configure(0, 2'b00, 8'd4, 3'b001, 0);
        while (!tx_tick) @(negedge clk);
        check(sclk_out == 1'b0, "R6", "sclk_out at tx tick", sclk_out, 0);
        @(negedge clk) cfg_clk_inv = 1'b1;
        @(negedge clk);
        while (!tx_tick) @(negedge clk);
        check(sclk_out == 1'b1, "R8", "inverted sclk_out at tx tick", sclk_out, 1);
        @(negedge clk) cfg_clk_inv = 1'b0;

        // R4 reload: change n mid-interval, old interval must complete
        configure(0, 2'b00, 8'd9, 3'b001, 0);
        repeat (30) @(negedge clk);
        prev = sclk_out;
        while (sclk_out == prev) @(negedge clk);
        repeat (4) @(negedge clk);
        cfg_div_n = 8'd2;
        gap = 4;
        prev = sclk_out;
        while (sclk_out == prev && gap < 100) begin @(negedge clk); gap++; end
        check(gap == 10, "R4", "interval in progress at n change", gap, 10);
        gap = 0;
        prev = sclk_out;
        while (sclk_out == prev && gap < 100) begin @(negedge clk); gap++; end
        check(gap == 3, "R4", "interval after reload with new n", gap, 3);

        // R7 external clock: tick on third rising edge after pin change
        configure(0, 2'b00, 8'd0, 3'b001, 1);
        repeat (6) @(negedge clk);
        check(!sclk_oe, "R7", "clock pin not driven", sclk_oe, 0);
        sclk_in = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(!tx_tick, "R7", "tx tick too early", tx_tick, 0);
        @(posedge clk); #1;
        check(tx_tick && !rx_tick, "R7", "tx tick after falling pin", tx_tick, 1);
        @(posedge clk); #1;
        check(!tx_tick, "R7", "tx tick width", tx_tick, 0);
        @(negedge clk) sclk_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        check(rx_tick && !tx_tick, "R7", "rx tick after rising pin", rx_tick, 1);
        // R8 external with inversion: rising pin gives tx
        @(negedge clk) sclk_in = 1'b0;
        repeat (5) @(negedge clk);
        cfg_clk_inv = 1'b1;
        repeat (5) @(negedge clk);
        sclk_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        check(tx_tick && !rx_tick, "R8", "inverted rising pin gives tx", tx_tick, 1);
        @(negedge clk) cfg_clk_inv = 1'b0;

        // R9 data polarity
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {cfg_rx_inv, rxd_pin, cfg_tx_inv} = v[2:0];
            txd_core = v[0] ^ v[1];
            #1;
            check(rxd_core == (rxd_pin ^ cfg_rx_inv) && txd_pin == (txd_core ^ cfg_tx_inv),
                  "R9", $sformatf("data polarity case %0d", v), {rxd_core, txd_pin},
                  {rxd_pin ^ cfg_rx_inv, txd_core ^ cfg_tx_inv});
        end

        // R10 handshake routing
        @(negedge clk) begin cfg_hs_off = 1'b1; hs_pin_in = 1'b1; end
        #1 check(!hs_pin_oe && cts_n_core == 1'b0, "R10", "disabled: (oe,cts)",
                 {hs_pin_oe, cts_n_core}, 0);
        @(negedge clk) begin cfg_hs_off = 1'b0; cfg_hs_rts = 1'b1; rts_n_core = 1'b0; end
        #1 check(hs_pin_oe && hs_pin_out == 1'b0, "R10", "RTS low: (oe,out)",
                 {hs_pin_oe, hs_pin_out}, 2);
        @(negedge clk) rts_n_core = 1'b1;
        #1 check(hs_pin_out == 1'b1, "R10", "RTS high", hs_pin_out, 1);
        @(negedge clk) begin cfg_hs_rts = 1'b0; hs_pin_in = 1'b1; end
        #1 check(!hs_pin_oe && cts_n_core == 1'b1, "R10", "CTS input high: (oe,cts)",
                 {hs_pin_oe, cts_n_core}, 1);
        @(negedge clk) hs_pin_in = 1'b0;
        #1 check(cts_n_core == 1'b0, "R10", "CTS input low", cts_n_core, 0);

        // R11 disabled modes and R3 unused source
        configure(0, 2'b00, 8'd0, 3'b000, 0);  expect_silence("R11", 400);
        configure(0, 2'b00, 8'd0, 3'b011, 0);  expect_silence("R11", 400);
        configure(0, 2'b00, 8'd0, 3'b111, 0);  expect_silence("R11", 400);
        configure(0, 2'b11, 8'd0, 3'b010, 0);  expect_silence("R3", 1000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule